// File: doc/BRIEF.md
# Infrared Pulse Width Receiver

The block times the marks and spaces of an already demodulated infrared signal. A programmable edge trigger chooses which transitions start and stop a measurement. Each completed pulse becomes one record in a small receive FIFO, holding the pulse duration and the level the input had during it. The duration comes from a pulse-width counter that advances on every underflow of a programmable receive clock divider. The FIFO exposes only the upper part of that counter.

A glitch filter in front of the timer discards input pulses shorter than a programmable number of clock cycles. If the counter overflows because the line went quiet, the block raises a sticky timeout status. It can also write an all-ones end-of-message marker. A loopback select lets the transmitter's output drive the receiver for self-test. The host pops words from the FIFO; each word carries a flag saying whether it holds new data. A service-request output tells the host when the FIFO wants draining.

Top module: `ir_pw_rx`

## Requirements
- R1: `cfg_edge` selects the measurement trigger: 0 never triggers, 1 triggers on falling edges, 2 on rising edges, 3 on both. The first trigger starts a measurement. Every later trigger stores a record and restarts the measurement. With `cfg_edge`=0 no record is ever stored and `busy` stays low.
- R2: The pulse-width counter is `CNT_W` (default 18) bits wide. It starts at 0 on a trigger and increments once every `cfg_clk_div`+1 clock cycles. For an input pulse of P cycles between two triggers, the stored count is floor((P-1)/(`cfg_clk_div`+1)).
- R3: A record stores counter bits [CNT_W-1:2] in bits [CNT_W-3:0]. Bit CNT_W-2 holds the input level during the measured pulse (bit 16 at default). A `pop` loads `rd_data` on the next edge, with bit CNT_W-1 (bit 17) set when a record was popped. Popping an empty FIFO returns all zeros.
- R4: An increment from an all-ones counter is an overflow and ends the measurement. On overflow a marker with the low CNT_W-1 bits all ones is stored, unless `cfg_no_tmo_mark` is 1.
- R5: Overflow sets `timeout_sts`. It stays set while `cfg_rx_en` is 1 and clears while `cfg_rx_en` is 0.
- R6: The FIFO holds `FIFO_DEPTH` (default 8) records. A record arriving at a full FIFO is dropped and sets `overrun_sts`. That status stays set while `cfg_fifo_en` is 1. Setting `cfg_fifo_en` to 0 clears the status and empties the FIFO.
- R7: When `cfg_svc_not_empty` is 0, `svc_req` is high while the FIFO holds at least FIFO_DEPTH/2 records. When it is 1, `svc_req` is high while the FIFO holds at least one record.
- R8: When `cfg_lpf_count` is 4 or more, an input level must persist for `cfg_lpf_count` cycles before the timer sees it, so shorter pulses are discarded. Below 4 the filter is bypassed and a 2-cycle pulse is measured.
- R9: When `cfg_loopback` is 1, `tx_loop_in` replaces `ir_in` as the receiver input.
- R10: `busy` is high from the trigger that starts a measurement until overflow or until `cfg_rx_en` goes low.
- R11: After reset, `rd_data`, `svc_req`, `timeout_sts`, `overrun_sts` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 1 | Demodulated infrared input |
| tx_loop_in | input | 1 | Transmitter output for loopback |
| cfg_rx_en | input | 1 | Receiver enable; low clears timeout and stops timing |
| cfg_fifo_en | input | 1 | FIFO enable; low flushes and clears overrun |
| cfg_edge | input | 2 | Trigger select (none, fall, rise, both) |
| cfg_no_tmo_mark | input | 1 | Suppress the overflow marker |
| cfg_svc_not_empty | input | 1 | Service request on not empty instead of half full |
| cfg_loopback | input | 1 | Select tx_loop_in as receiver input |
| cfg_clk_div | input | DIV_W | Receive clock divider reload value |
| cfg_lpf_count | input | LPF_W | Glitch filter minimum width in cycles |
| pop | input | 1 | Pop one FIFO word into rd_data |
| rd_data | output | CNT_W | Valid flag, level and count of the popped word |
| svc_req | output | 1 | FIFO service request |
| timeout_sts | output | 1 | Sticky counter-overflow status |
| overrun_sts | output | 1 | Sticky FIFO overrun status |
| busy | output | 1 | Measurement in progress |

## Verification
The assertions check on every cycle that the sticky timeout and overrun flags hold until their own enable drops, and that disabling the FIFO clears both the service request and the overrun flag. They also check that `busy` falls whenever the receiver is disabled, that a timeout rises only out of a running measurement, and that the "none" trigger never starts one. Only the scenarios can show the measured values themselves. These are the counts for several pulse widths and divider settings, the level bit, the marker word, and that a ninth record is dropped. They also cover the service-request thresholds, the discarding of glitches, and the loopback path.

// File: rtl/ir_pw_pkg.sv
package ir_pw_pkg;
  typedef enum logic [1:0] {
    TRIG_NONE = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_sel_e;

  localparam int LPF_MIN_COUNT = 4;
endpackage

// File: rtl/ir_glitch_filter.sv
module ir_glitch_filter #(
  parameter int LPF_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [LPF_W-1:0] min_count,
  output logic             dout
);
  import ir_pw_pkg::*;

  logic             din_q;
  logic [LPF_W-1:0] run;
  logic [LPF_W:0]   run_inc;
  logic             bypass;

  assign run_inc = {1'b0, run} + (LPF_W+1)'(1);
  assign bypass  = min_count < LPF_W'(LPF_MIN_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      din_q <= 1'b0;
      dout  <= 1'b0;
      run   <= '0;
    end else begin
      din_q <= din;
      if (bypass) begin
        dout <= din_q;
        run  <= '0;
      end else if (din_q == dout) begin
        run <= '0;
      end else if (run_inc >= {1'b0, min_count}) begin
        dout <= din_q;
        run  <= '0;
      end else begin
        run <= run_inc[LPF_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ir_pulse_timer.sv
module ir_pulse_timer #(
  parameter int CNT_W = 18,
  parameter int DIV_W = 16,
  localparam int REC_W = CNT_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             level,
  input  logic [1:0]       trig_sel,
  input  logic [DIV_W-1:0] div,
  input  logic             no_mark,
  output logic             rec_push,
  output logic [REC_W-1:0] rec_data,
  output logic             timeout,
  output logic             busy
);
  import ir_pw_pkg::*;

  logic             prev;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] pre;
  logic             trig;

  always_comb begin
    case (trig_sel_e'(trig_sel))
      TRIG_FALL: trig = prev & ~level;
      TRIG_RISE: trig = level & ~prev;
      TRIG_BOTH: trig = level ^ prev;
      default:   trig = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= level;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy     <= 1'b0;
      cnt      <= '0;
      pre      <= '0;
      rec_push <= 1'b0;
      rec_data <= '0;
      timeout  <= 1'b0;
    end else begin
      rec_push <= 1'b0;
      if (trig) begin
        if (busy) begin
          rec_push <= 1'b1;
          rec_data <= {prev, cnt[CNT_W-1:2]};
        end
        busy <= 1'b1;
        cnt  <= '0;
        pre  <= div;
      end else if (busy) begin
        if (pre == '0) begin
          pre <= div;
          if (&cnt) begin
            busy     <= 1'b0;
            timeout  <= 1'b1;
            rec_push <= !no_mark;
            rec_data <= '1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end else begin
          pre <= pre - DIV_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         svc_on_any,
  output logic [W:0]   rd_word,
  output logic         svc,
  output logic         overrun
);
  localparam int HALF = DEPTH / 2;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt, cnt_nxt;
  logic          full, empty, do_w, do_r;

  assign full  = cnt == (AW+1)'(DEPTH);
  assign empty = cnt == '0;
  assign do_w  = en && push && !full;
  assign do_r  = pop && !empty;

  always_comb begin
    cnt_nxt = cnt;
    if (!en)              cnt_nxt = '0;
    else if (do_w && !do_r) cnt_nxt = cnt + (AW+1)'(1);
    else if (do_r && !do_w) cnt_nxt = cnt - (AW+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (do_w) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_word <= '0;
    else if (pop) rd_word <= empty ? '0 : {1'b1, mem[rp]};
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      svc     <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (do_w) wp <= wp + AW'(1);
      if (do_r) rp <= rp + AW'(1);
      cnt <= cnt_nxt;
      svc <= svc_on_any ? (cnt_nxt != '0) : (int'(cnt_nxt) >= HALF);
      if (push && full) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/ir_pw_rx.sv
module ir_pw_rx #(
  parameter int CNT_W      = 18,
  parameter int DIV_W      = 16,
  parameter int LPF_W      = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ir_in,
  input  logic             tx_loop_in,
  input  logic             cfg_rx_en,
  input  logic             cfg_fifo_en,
  input  logic [1:0]       cfg_edge,
  input  logic             cfg_no_tmo_mark,
  input  logic             cfg_svc_not_empty,
  input  logic             cfg_loopback,
  input  logic [DIV_W-1:0] cfg_clk_div,
  input  logic [LPF_W-1:0] cfg_lpf_count,
  input  logic             pop,
  output logic [CNT_W-1:0] rd_data,
  output logic             svc_req,
  output logic             timeout_sts,
  output logic             overrun_sts,
  output logic             busy
);
  localparam int REC_W = CNT_W - 1;

  logic             src, filt, push;
  logic [REC_W-1:0] rec;

  assign src = cfg_loopback ? tx_loop_in : ir_in;

  ir_glitch_filter #(.LPF_W(LPF_W)) u_filt (
    .clk(clk), .rst(rst), .din(src), .min_count(cfg_lpf_count), .dout(filt)
  );

  ir_pulse_timer #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_tmr (
    .clk(clk), .rst(rst), .en(cfg_rx_en), .level(filt), .trig_sel(cfg_edge),
    .div(cfg_clk_div), .no_mark(cfg_no_tmo_mark), .rec_push(push),
    .rec_data(rec), .timeout(timeout_sts), .busy(busy)
  );

  ir_rx_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .en(cfg_fifo_en), .push(push), .push_data(rec),
    .pop(pop), .svc_on_any(cfg_svc_not_empty), .rd_word(rd_data),
    .svc(svc_req), .overrun(overrun_sts)
  );
endmodule

// File: rtl/ir_pw_rx_chk.sv
module ir_pw_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_rx_en,
  input logic       cfg_fifo_en,
  input logic [1:0] cfg_edge,
  input logic       svc_req,
  input logic       timeout_sts,
  input logic       overrun_sts,
  input logic       busy
);
  // R10
  busy_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_rx_en |=> !busy);
  // R5
  timeout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_sts && cfg_rx_en |=> timeout_sts);
  // R5
  timeout_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_sts) |-> $past(busy));
  // R6
  overrun_hold_chk: assert property (@(posedge clk) disable iff (rst)
    overrun_sts && cfg_fifo_en |=> overrun_sts);
  // R7
  svc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_fifo_en |=> !svc_req && !overrun_sts);
  // R1
  edge_none_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_edge == 2'd0 && !busy |=> !busy);
endmodule

bind ir_pw_rx ir_pw_rx_chk u_chk (
  .clk(clk), .rst(rst), .cfg_rx_en(cfg_rx_en), .cfg_fifo_en(cfg_fifo_en),
  .cfg_edge(cfg_edge), .svc_req(svc_req), .timeout_sts(timeout_sts),
  .overrun_sts(overrun_sts), .busy(busy)
);

// File: tb/sim_ir_pw_rx.sv
`timescale 1ns/1ps
module sim_ir_pw_rx;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ir_in = 1'b0, tx_loop_in = 1'b0;
  logic cfg_rx_en = 1'b0, cfg_fifo_en = 1'b0;
  logic [1:0] cfg_edge = 2'd3;
  logic cfg_no_tmo_mark = 1'b0, cfg_svc_not_empty = 1'b0, cfg_loopback = 1'b0;
  logic [15:0] cfg_clk_div = 16'd0, cfg_lpf_count = 16'd0;
  logic pop = 1'b0;
  logic [CW-1:0] rd_data;
  logic svc_req, timeout_sts, overrun_sts, busy;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ir_pw_rx #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .ir_in(ir_in), .tx_loop_in(tx_loop_in),
    .cfg_rx_en(cfg_rx_en), .cfg_fifo_en(cfg_fifo_en), .cfg_edge(cfg_edge),
    .cfg_no_tmo_mark(cfg_no_tmo_mark), .cfg_svc_not_empty(cfg_svc_not_empty),
    .cfg_loopback(cfg_loopback), .cfg_clk_div(cfg_clk_div),
    .cfg_lpf_count(cfg_lpf_count), .pop(pop), .rd_data(rd_data),
    .svc_req(svc_req), .timeout_sts(timeout_sts), .overrun_sts(overrun_sts),
    .busy(busy)
  );

  function automatic logic [CW-1:0] word(input logic lvl, input int p_cnt);
    return {1'b1, lvl, 8'(p_cnt >> 2)};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    ir_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic pop_word(output logic [CW-1:0] w);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    w = rd_data;
  endtask

  task automatic restart();
    cfg_rx_en = 1'b0; cfg_fifo_en = 1'b0;
    ir_in = 1'b0; tx_loop_in = 1'b0;
    repeat (12) @(negedge clk);
    cfg_rx_en = 1'b1; cfg_fifo_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 rd_data", int'(rd_data), 0);
    check("R11 svc_req", int'(svc_req), 0);
    check("R11 timeout", int'(timeout_sts), 0);
    check("R11 overrun", int'(overrun_sts), 0);
    check("R11 busy", int'(busy), 0);
  endtask

  task automatic t_both();
    logic [CW-1:0] w;
    cfg_edge = 2'd3; cfg_clk_div = 16'd0; restart();
    hold(1, 40);
    check("R10 busy during pulse", int'(busy), 1);
    hold(0, 20); hold(1, 60); hold(0, 8);
    pop_word(w); check("R2 both mark 40", int'(w), int'(word(1, 39)));
    pop_word(w); check("R3 space level 0", int'(w), int'(word(0, 19)));
    pop_word(w); check("R2 both mark 60", int'(w), int'(word(1, 59)));
    pop_word(w); check("R3 empty pop valid=0", int'(w), 0);
  endtask

  task automatic t_div();
    logic [CW-1:0] w;
    cfg_edge = 2'd3; cfg_clk_div = 16'd1; restart();
    hold(1, 40); hold(0, 8);
    pop_word(w); check("R2 divider 1", int'(w), int'(word(1, 39 / 2)));
    cfg_clk_div = 16'd4; restart();
    hold(1, 100); hold(0, 8);
    pop_word(w); check("R2 divider 4", int'(w), int'(word(1, 99 / 5)));
    cfg_clk_div = 16'd0;
  endtask

  task automatic t_rise();
    logic [CW-1:0] w;
    cfg_edge = 2'd2; restart();
    hold(1, 10); hold(0, 30); hold(1, 10); hold(0, 8);
    pop_word(w); check("R1 rise period", int'(w), int'(word(0, 39)));
    pop_word(w); check("R1 rise single record", int'(w), 0);
    cfg_edge = 2'd1; restart();
    hold(1, 10); hold(0, 30); hold(1, 10); hold(0, 8);
    pop_word(w); check("R1 fall period", int'(w), int'(word(1, 39)));
  endtask

  task automatic t_none();
    logic [CW-1:0] w;
    cfg_edge = 2'd0; restart();
    hold(1, 10); hold(0, 10); hold(1, 10); hold(0, 8);
    check("R1 none busy", int'(busy), 0);
    pop_word(w); check("R1 none no record", int'(w), 0);
    cfg_edge = 2'd3;
  endtask

  task automatic t_overflow();
    logic [CW-1:0] w;
    cfg_edge = 2'd3; cfg_no_tmo_mark = 1'b0; restart();
    hold(1, 1100);
    check("R5 timeout set", int'(timeout_sts), 1);
    check("R10 busy after overflow", int'(busy), 0);
    pop_word(w); check("R4 marker", int'(w), (1 << CW) - 1);
    repeat (20) @(negedge clk);
    check("R5 timeout sticky", int'(timeout_sts), 1);
    cfg_rx_en = 1'b0; @(negedge clk); @(negedge clk);
    check("R5 timeout cleared", int'(timeout_sts), 0);
    cfg_no_tmo_mark = 1'b1; restart();
    hold(1, 1100);
    check("R5 timeout no-mark", int'(timeout_sts), 1);
    pop_word(w); check("R4 marker suppressed", int'(w), 0);
    cfg_no_tmo_mark = 1'b0;
  endtask

  task automatic t_fifo();
    logic [CW-1:0] w;
    cfg_edge = 2'd3; cfg_svc_not_empty = 1'b0; restart();
    hold(~ir_in, 8);
    for (int i = 0; i < 3; i++) hold(~ir_in, 8);
    check("R7 svc below half", int'(svc_req), 0);
    hold(~ir_in, 8);
    check("R7 svc at half", int'(svc_req), 1);
    for (int i = 0; i < 4; i++) hold(~ir_in, 8);
    check("R6 no overrun at full", int'(overrun_sts), 0);
    hold(~ir_in, 8);
    check("R6 overrun set", int'(overrun_sts), 1);
    for (int i = 0; i < 8; i++) begin
      pop_word(w); check("R6 stored record valid", int'(w[CW-1]), 1);
    end
    pop_word(w); check("R6 ninth dropped", int'(w), 0);
    check("R6 overrun sticky", int'(overrun_sts), 1);
    cfg_rx_en = 1'b0; cfg_fifo_en = 1'b0; @(negedge clk); @(negedge clk);
    check("R6 overrun cleared", int'(overrun_sts), 0);
    cfg_svc_not_empty = 1'b1; restart();
    hold(1, 10); hold(0, 8);
    check("R7 svc not empty", int'(svc_req), 1);
    pop_word(w);
    check("R7 svc after drain", int'(svc_req), 0);
    cfg_svc_not_empty = 1'b0;
  endtask

  task automatic t_filter();
    logic [CW-1:0] w;
    cfg_edge = 2'd3; cfg_lpf_count = 16'd8; restart();
    hold(1, 5); hold(0, 20);
    check("R8 glitch ignored", int'(busy), 0);
    hold(1, 40); hold(0, 20);
    pop_word(w); check("R8 long pulse kept", int'(w), int'(word(1, 39)));
    pop_word(w); check("R8 glitch no record", int'(w), 0);
    cfg_lpf_count = 16'd3; restart();
    hold(1, 2); hold(0, 8);
    pop_word(w); check("R8 bypass short pulse", int'(w), int'(word(1, 1)));
    cfg_lpf_count = 16'd0;
  endtask

  task automatic t_loop();
    logic [CW-1:0] w;
    cfg_edge = 2'd3; cfg_loopback = 1'b1; restart();
    tx_loop_in = 1'b1; repeat (40) @(negedge clk);
    tx_loop_in = 1'b0; repeat (8) @(negedge clk);
    pop_word(w); check("R9 loopback record", int'(w), int'(word(1, 39)));
    cfg_loopback = 1'b0; restart();
    tx_loop_in = 1'b1; repeat (40) @(negedge clk);
    tx_loop_in = 1'b0; repeat (8) @(negedge clk);
    check("R9 tx ignored without loopback", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_both();
    t_div();
    t_rise();
    t_none();
    t_overflow();
    t_fifo();
    t_filter();
    t_loop();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule